// File: doc/BRIEF.md
# Serial CRC Signature Analyzer

This block reduces a serial test-response bit stream to a short signature. It divides the stream, read as a polynomial, by the fixed polynomial X^5 + X^3 + X + 1. A five-stage shift register does the division, with XOR gates between its stages at the tap positions. Whatever is left in the register when the stream ends is the remainder, and that remainder is the signature.

Before a test, the controller pulses a clear so that the register starts from zero. It then presents one response bit per clock with shift-enable high, sending the highest-degree coefficient first. After the last bit it raises a done strobe. On that strobe the block compares the held signature with a golden value supplied on a port. From the next cycle it reports a verdict flag and a pass flag, and keeps them until the register is cleared or shifted again.

Top module: `sig_analyzer`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, signature_o is 00000, verdict_valid_o is 0 and pass_o is 0.
- R2: When clear_i is high at a clock edge, the next signature_o is 00000 and verdict_valid_o is 0, whatever shift_en_i, data_i and done_i are.
- R3: When clear_i and shift_en_i are both low at a clock edge, signature_o keeps its value.
- R4: Bit i of signature_o holds coefficient X^i (bit 0 is X^0). A shift with input bit d and old stages q gives: X0 = d^q4, X1 = q0^q4, X2 = q1, X3 = q2^q4, X4 = q3.
- R5: After a clear, shifting any stream in highest-degree-first order leaves the remainder of the stream polynomial divided by X^5+X^3+X+1. The stream X+X^3+X^7 is applied in time as 1,0,0,0,1,0,1,0 and leaves X0..X4 = 1,0,1,1,0 (signature_o = 5'b01101).
- R6: When done_i is high and clear_i is low at an edge, verdict_valid_o is 1 from the next cycle. At the same time pass_o is 1 exactly when the signature before that edge equalled golden_i.
- R7: verdict_valid_o stays set until an edge with clear_i, or with shift_en_i high and done_i low. pass_o is never 1 while verdict_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear to the zero seed |
| shift_en_i | input | 1 | Shift one data bit into the divider |
| data_i | input | 1 | Serial response bit, highest degree first |
| done_i | input | 1 | End-of-stream strobe that requests the comparison |
| golden_i | input | 5 | Fault-free signature to compare against |
| signature_o | output | 5 | Current remainder, bit i = coefficient X^i |
| verdict_valid_o | output | 1 | Comparison result is valid |
| pass_o | output | 1 | Signature matched golden_i |

## Verification
All 256 eight-bit streams are compacted, together with a set of twelve-bit streams. The expected remainders come from long division on integers in the bench. The eight-bit sweep covers every remainder class and the worked example. The longer streams exercise repeated feedback through X4. Each stream is checked once against its true remainder, so that a pass is expected, and once against that remainder with one bit flipped, so that a fail is expected. Separate directed sequences test that the register holds while shift-enable is low, that clear wins over shift and done, and that the verdict drops when a new shift starts.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int SA_W = 5;
  // bit i set = coefficient X^i of the divisor (X^5 implied)
  localparam logic [SA_W-1:0] SA_TAPS = 5'b01011;
  localparam logic [SA_W-1:0] SA_SEED = '0;

  typedef struct packed {
    logic valid;
    logic pass;
  } verdict_t;
endpackage

// File: rtl/sa_div_reg.sv
module sa_div_reg #(
  parameter int W = sa_pkg::SA_W,
  parameter logic [W-1:0] TAPS = sa_pkg::SA_TAPS,
  parameter logic [W-1:0] SEED = sa_pkg::SA_SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         shift_i,
  input  logic         data_i,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] q, nxt;
  logic         fb;

  assign fb = q[W-1];

  generate
    for (genvar i = 0; i < W; i++) begin : g_stage
      if (i == 0) begin : g_in
        assign nxt[i] = data_i ^ (TAPS[i] & fb);
      end else begin : g_mid
        assign nxt[i] = q[i-1] ^ (TAPS[i] & fb);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= SEED;
    else if (clear_i) q <= SEED;
    else if (shift_i) q <= nxt;
  end

  assign rem_o = q;

  // R2: clear forces the seed
  p_clear_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> rem_o == SEED);
  // R3: hold while idle
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !shift_i) |=> $stable(rem_o));
  // R4: without feedback the register is a plain shift
  p_plain_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && shift_i && !q[W-1]) |=>
      (rem_o[W-1:1] == $past(q[W-2:0])) && (rem_o[0] == $past(data_i)));
  // R4: with feedback the input stage inverts the data bit
  p_fb_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && shift_i && q[W-1]) |=> rem_o[0] == !$past(data_i));
endmodule

// File: rtl/sa_verdict.sv
module sa_verdict #(
  parameter int W = sa_pkg::SA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             done_i,
  input  logic [W-1:0]     sig_i,
  input  logic [W-1:0]     golden_i,
  output sa_pkg::verdict_t verdict_o
);
  import sa_pkg::*;

  logic     match_now;
  verdict_t v_q;

  assign match_now = (sig_i == golden_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (clear_i) begin
      v_q <= '0;
    end else if (done_i) begin
      v_q.valid <= 1'b1;
      v_q.pass  <= match_now;
    end else if (shift_i) begin
      v_q <= '0;
    end
  end

  assign verdict_o = v_q;

  // R6: done yields a valid verdict reflecting the pre-edge comparison
  p_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !clear_i) |=> verdict_o.valid && (verdict_o.pass == $past(match_now)));
  // R7: pass only with valid
  p_pass_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_o.pass |-> verdict_o.valid);
  // R7: new shift without done clears the verdict
  p_shift_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !done_i) |=> !verdict_o.valid);
  // R2: clear clears the verdict
  p_clear_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !verdict_o.valid);
endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer #(
  parameter int W = sa_pkg::SA_W,
  parameter logic [W-1:0] TAPS = sa_pkg::SA_TAPS,
  parameter logic [W-1:0] SEED = sa_pkg::SA_SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         shift_en_i,
  input  logic         data_i,
  input  logic         done_i,
  input  logic [W-1:0] golden_i,
  output logic [W-1:0] signature_o,
  output logic         verdict_valid_o,
  output logic         pass_o
);
  import sa_pkg::*;

  logic [W-1:0] rem;
  verdict_t     verdict;

  sa_div_reg #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .shift_i (shift_en_i),
    .data_i  (data_i),
    .rem_o   (rem)
  );

  sa_verdict #(.W(W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .shift_i   (shift_en_i),
    .done_i    (done_i),
    .sig_i     (rem),
    .golden_i  (golden_i),
    .verdict_o (verdict)
  );

  assign signature_o     = rem;
  assign verdict_valid_o = verdict.valid;
  assign pass_o          = verdict.pass;

  // R1: reset state holds in the first cycle after release
  p_reset_state_r1: assert property (@(posedge clk)
    (!rst_n) |=> (signature_o == SEED) && !verdict_valid_o && !pass_o);
endmodule

// File: tb/sim_sig_analyzer.sv
module sim_sig_analyzer;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [5:0] DIVISOR = 6'b101011;

  logic clk = 1'b0;
  logic rst_n, clear_i, shift_en_i, data_i, done_i;
  logic [4:0] golden_i, signature_o;
  logic verdict_valid_o, pass_o;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_analyzer u0 (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .shift_en_i(shift_en_i),
    .data_i(data_i), .done_i(done_i), .golden_i(golden_i),
    .signature_o(signature_o), .verdict_valid_o(verdict_valid_o), .pass_o(pass_o)
  );

  function automatic logic [4:0] remainder(input logic [15:0] m, input int len);
    logic [15:0] r = m;
    for (int k = len - 1; k >= 5; k--)
      if (r[k]) r = r ^ (16'(DIVISOR) << (k - 5));
    return r[4:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic s, input logic d, input logic dn);
    clear_i = c; shift_en_i = s; data_i = d; done_i = dn;
    @(negedge clk);
  endtask

  task automatic run_stream(input logic [15:0] m, input int len);
    logic [4:0] exp = remainder(m, len);
    cyc(1, 0, 0, 0);
    for (int k = len - 1; k >= 0; k--) cyc(0, 1, m[k], 0);
    check("R5", {3'b0, signature_o}, {3'b0, exp});
    golden_i = exp;
    cyc(0, 0, 0, 1);
    check("R6 pass", {6'b0, verdict_valid_o, pass_o}, 8'b11);
    cyc(0, 0, 0, 0);
    check("R7 held", {6'b0, verdict_valid_o, pass_o}, 8'b11);
    golden_i = exp ^ 5'(1 << (m % 5));
    cyc(0, 0, 0, 1);
    check("R6 fail", {6'b0, verdict_valid_o, pass_o}, 8'b10);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] q;
    rst_n = 0; clear_i = 0; shift_en_i = 0; data_i = 0; done_i = 0; golden_i = '0;
    @(negedge clk); @(negedge clk);
    check("R1", {2'b0, signature_o, verdict_valid_o, pass_o}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {2'b0, signature_o, verdict_valid_o, pass_o}, 8'h00);

    // R5 worked example: X+X^3+X^7 applied as 1,0,0,0,1,0,1,0
    cyc(1, 0, 0, 0);
    for (int k = 7; k >= 0; k--) cyc(0, 1, 8'b1000_1010 >> k & 1, 0);
    check("R5 example", {3'b0, signature_o}, 8'b01101);

    // R3 hold
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, 0);
    check("R3 hold", {3'b0, signature_o}, 8'b01101);

    // R4 single steps from 01101 (q4=0) then walk with feedback
    q = 5'b01101;
    for (int k = 0; k < 6; k++) begin
      logic d = k[0];
      logic [4:0] n;
      n[0] = d ^ q[4]; n[1] = q[0] ^ q[4]; n[2] = q[1]; n[3] = q[2] ^ q[4]; n[4] = q[3];
      cyc(0, 1, d, 0);
      check("R4 step", {3'b0, signature_o}, {3'b0, n});
      q = n;
    end

    // R2 clear beats shift and done
    golden_i = 5'b0;
    cyc(1, 1, 1, 1);
    check("R2 clear priority", {2'b0, signature_o, verdict_valid_o, pass_o}, 8'h00);

    // R7 verdict dropped by a new shift
    golden_i = 5'b0;
    cyc(0, 0, 0, 1);
    check("R6 zero match", {6'b0, verdict_valid_o, pass_o}, 8'b11);
    cyc(0, 1, 1, 0);
    check("R7 shift drops", {6'b0, verdict_valid_o, pass_o}, 8'b00);
    cyc(0, 0, 0, 1);
    cyc(1, 0, 0, 0);
    check("R7 clear drops", {6'b0, verdict_valid_o, pass_o}, 8'b00);

    // R5 exhaustive 8-bit sweep
    for (int m = 0; m < 256; m++) run_stream(16'(m), 8);
    // R5 twelve-bit streams
    for (int m = 0; m < 4096; m += 37) run_stream(16'(m), 12);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule